// File: doc/BRIEF.md
# GF(2^8) Byte Affine Transform Unit

This block applies an affine map over GF(2^8) to every byte of a wide source vector. Each 64-bit lane of a matrix operand holds one 8x8 bit matrix. Every output bit is the parity of one matrix row ANDed with the source byte, then XORed with one bit of an 8-bit constant. All eight bytes in a lane share that lane's matrix. A broadcast select makes every lane use the matrix in lane 0.

Per-byte write masking is applied after the transform. With masking disabled, every byte is written. With masking enabled, a byte whose mask bit is clear is either zeroed or given the matching byte of the previous destination value, depending on the zero-mode select. A vector-length select limits the active width to 128, 256 or 512 bits. All bytes above that width are forced to zero. The result is captured one cycle after an input strobe, with a matching one-cycle valid pulse.

Top module: `gf_aff_vec`

## Requirements
- R1: Output bit i of a result byte equals the parity (XOR of all bits) of (matrix byte 7-i AND source byte), XORed with bit i of `const_i`. Matrix byte k of a lane occupies bits [8k+7:8k] of that lane's 64-bit slice.
- R2: Without broadcast, the bytes at indices 8j to 8j+7 (lane j) all use the matrix held in bits [64j+63:64j] of `mat_i`.
- R3: With `bcast_i`=1, every lane uses `mat_i[63:0]` as its matrix.
- R4: `vlen_i` selects the active width: 2'b00 gives 128 bits (2 lanes), 2'b01 gives 256 bits (4 lanes), and 2'b10 or 2'b11 gives 512 bits (8 lanes). Every result bit at or above the active width is zero, whatever the mask, mode or previous value.
- R5: With `mask_en_i`=0, every byte inside the active width receives its transformed value, regardless of `mask_i` and `zero_mode_i`.
- R6: With `mask_en_i`=1 and `zero_mode_i`=0, an active byte b whose `mask_i[b]` is 0 takes byte b of `prev_i`. Byte b occupies bits [8b+7:8b], and b = lane*8 + byte.
- R7: With `mask_en_i`=1 and `zero_mode_i`=1, an active byte b whose `mask_i[b]` is 0 is zero.
- R8: `result_o` is updated on the first rising clock edge at which `valid_i` is high. `valid_o` is high for exactly the cycle after each cycle in which `valid_i` is high, and low otherwise.
- R9: While `valid_i` is low, `result_o` keeps its value.
- R10: During reset, `result_o` and `valid_o` are zero.
- R11: The identity matrix 0x0102040810204080 with a zero constant passes each source byte through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| data_i | input | 512 | Source byte vector |
| mat_i | input | 512 | One 8x8 bit matrix per 64-bit lane |
| const_i | input | 8 | Affine constant |
| mask_i | input | 64 | Per-byte write mask |
| mask_en_i | input | 1 | Enables masking |
| zero_mode_i | input | 1 | 1: zero masked-off bytes; 0: merge from prev_i |
| bcast_i | input | 1 | All lanes use matrix lane 0 |
| vlen_i | input | 2 | Active vector length select |
| prev_i | input | 512 | Previous destination value, used for merging |
| result_o | output | 512 | Registered result |
| valid_o | output | 1 | Result valid pulse |

## Verification
The assertions check on every cycle that the valid pulse follows the strobe by one cycle, that the result register holds while there is no strobe, that bytes above a 128-bit length come out zero, and that masked-off bytes in zero mode come out zero. The bench's scenarios are the only check of the arithmetic itself. They cover the row order, the constant, the per-lane and broadcast matrix choice, merge values and the identity pass-through. Each result is compared against a bit-serial reference model.

// File: rtl/gf_aff_pkg.sv
package gf_aff_pkg;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ROWS   = LANE_W / BYTE_W;

  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512X = 2'b11
  } vlen_e;
endpackage

// File: rtl/gf_aff_byte.sv
module gf_aff_byte
  import gf_aff_pkg::*;
(
  input  logic [LANE_W-1:0] mat_i,
  input  logic [BYTE_W-1:0] src_i,
  input  logic [BYTE_W-1:0] const_i,
  output logic [BYTE_W-1:0] res_o
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    // output bit i uses matrix row 7-i
    assign res_o[i] = ^(mat_i[BYTE_W*(ROWS-1-i) +: BYTE_W] & src_i) ^ const_i[i];
  end
endmodule

// File: rtl/gf_aff_lane.sv
module gf_aff_lane
  import gf_aff_pkg::*;
(
  input  logic [LANE_W-1:0] mat_i,
  input  logic [LANE_W-1:0] src_i,
  input  logic [BYTE_W-1:0] const_i,
  output logic [LANE_W-1:0] res_o
);
  for (genvar b = 0; b < ROWS; b++) begin : g_byte
    gf_aff_byte u_byte (
      .mat_i   (mat_i),
      .src_i   (src_i[BYTE_W*b +: BYTE_W]),
      .const_i (const_i),
      .res_o   (res_o[BYTE_W*b +: BYTE_W])
    );
  end
endmodule

// File: rtl/gf_aff_vec.sv
module gf_aff_vec
  import gf_aff_pkg::*;
#(
  parameter int unsigned W = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [W-1:0]      data_i,
  input  logic [W-1:0]      mat_i,
  input  logic [7:0]        const_i,
  input  logic [W/8-1:0]    mask_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic              bcast_i,
  input  logic [1:0]        vlen_i,
  input  logic [W-1:0]      prev_i,
  output logic [W-1:0]      result_o,
  output logic              valid_o
);
  localparam int unsigned LANES  = W / LANE_W;
  localparam int unsigned NBYTES = W / BYTE_W;

  logic [W-1:0] calc_d;
  logic [W-1:0] next_d;
  logic [7:0]   act_lanes;

  always_comb begin
    unique case (vlen_e'(vlen_i))
      VL_128:  act_lanes = 8'd2;
      VL_256:  act_lanes = 8'd4;
      default: act_lanes = 8'd8;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mat_sel;
    assign mat_sel = bcast_i ? mat_i[LANE_W-1:0] : mat_i[LANE_W*g +: LANE_W];
    gf_aff_lane u_lane (
      .mat_i   (mat_sel),
      .src_i   (data_i[LANE_W*g +: LANE_W]),
      .const_i (const_i),
      .res_o   (calc_d[LANE_W*g +: LANE_W])
    );
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_sel
    localparam int unsigned LN = b / ROWS;
    logic in_len, wr_en;
    assign in_len = 8'(LN) < act_lanes;
    assign wr_en  = !mask_en_i || mask_i[b];
    always_comb begin
      if (!in_len)          next_d[BYTE_W*b +: BYTE_W] = '0;
      else if (wr_en)       next_d[BYTE_W*b +: BYTE_W] = calc_d[BYTE_W*b +: BYTE_W];
      else if (zero_mode_i) next_d[BYTE_W*b +: BYTE_W] = '0;
      else                  next_d[BYTE_W*b +: BYTE_W] = prev_i[BYTE_W*b +: BYTE_W];
    end

    a_r7_zero_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i && mask_en_i && zero_mode_i && !mask_i[b])
      |-> result_o[BYTE_W*b +: BYTE_W] == '0);

    if (LN >= 2) begin : g_hi
      a_r4_above_len_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(valid_i && vlen_i == 2'b00) |-> result_o[BYTE_W*b +: BYTE_W] == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_d;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

// File: tb/gf_aff_vec_test.sv
module gf_aff_vec_test;
  localparam int W = 512;
  localparam int NB = W / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  data_i = '0, mat_i = '0, prev_i = '0;
  logic [7:0]    const_i = '0;
  logic [NB-1:0] mask_i = '0;
  logic          mask_en_i = 1'b0, zero_mode_i = 1'b0, bcast_i = 1'b0;
  logic [1:0]    vlen_i = 2'b10;
  logic [W-1:0]  result_o;
  logic          valid_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gf_aff_vec #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .mat_i(mat_i), .const_i(const_i), .mask_i(mask_i), .mask_en_i(mask_en_i),
    .zero_mode_i(zero_mode_i), .bcast_i(bcast_i), .vlen_i(vlen_i),
    .prev_i(prev_i), .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int k = 0; k < W / 32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  // bit-serial reference
  function automatic logic [W-1:0] ref_model();
    logic [W-1:0] r = '0;
    int lanes;
    lanes = (vlen_i == 2'b00) ? 2 : (vlen_i == 2'b01) ? 4 : 8;
    for (int b = 0; b < NB; b++) begin
      int ln;
      logic [63:0] m;
      logic [7:0] s, o;
      ln = b / 8;
      m = bcast_i ? mat_i[63:0] : mat_i[64*ln +: 64];
      s = data_i[8*b +: 8];
      for (int i = 0; i < 8; i++) begin
        logic p;
        p = const_i[i];
        for (int k = 0; k < 8; k++) p = p ^ (m[8*(7-i)+k] & s[k]);
        o[i] = p;
      end
      if (ln >= lanes) o = 8'h00;
      else if (mask_en_i && !mask_i[b]) o = zero_mode_i ? 8'h00 : prev_i[8*b +: 8];
      r[8*b +: 8] = o;
    end
    return r;
  endfunction

  task automatic check_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one strobe; check result and valid, then check hold cycle
  task automatic run_op(string req);
    logic [W-1:0] exp;
    @(negedge clk);
    exp = ref_model();
    valid_i = 1'b1;
    @(posedge clk); #1;
    check_bit({req, " R8 valid"}, valid_o, 1'b1);
    check_vec(req, result_o, exp);
    @(negedge clk);
    valid_i = 1'b0;
    data_i = rnd_vec();
    mat_i = rnd_vec();
    prev_i = rnd_vec();
    @(posedge clk); #1;
    check_bit("R8 valid low", valid_o, 1'b0);
    check_vec("R9 hold", result_o, exp);
  endtask

  task automatic set_plain();
    mask_en_i = 0; zero_mode_i = 0; bcast_i = 0; vlen_i = 2'b10;
    mask_i = '0; const_i = 8'h00;
  endtask

  task automatic t_reset();
    check_vec("R10 reset result", result_o, '0);
    check_bit("R10 reset valid", valid_o, 1'b0);
  endtask

  task automatic t_identity();
    set_plain();
    for (int j = 0; j < 8; j++) mat_i[64*j +: 64] = 64'h0102040810204080;
    data_i = rnd_vec();
    @(negedge clk);
    valid_i = 1'b1;
    @(posedge clk); #1;
    check_vec("R11 identity", result_o, data_i);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_single_bit();
    // row 7-0 = byte 7 selects bit 3 -> out bit0 = src bit3; const 0x80
    set_plain();
    mat_i = '0;
    mat_i[63:56] = 8'h08;
    data_i = '0;
    data_i[7:0] = 8'h08;
    const_i = 8'h80;
    @(negedge clk);
    valid_i = 1'b1;
    @(posedge clk); #1;
    check_vec("R1 row order byte0", {56'h0, result_o[7:0]}, {56'h0, 8'h81});
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_random_plain();
    for (int n = 0; n < 4; n++) begin
      set_plain();
      data_i = rnd_vec(); mat_i = rnd_vec(); const_i = 8'($urandom);
      mask_i = NB'(rnd_vec()); zero_mode_i = 1'($urandom);
      prev_i = rnd_vec();
      run_op("R1 R2 R5 random full");
    end
  endtask

  task automatic t_bcast();
    set_plain();
    bcast_i = 1; data_i = rnd_vec(); mat_i = rnd_vec(); const_i = 8'h5a;
    run_op("R3 broadcast");
  endtask

  task automatic t_vlen();
    for (int v = 0; v < 4; v++) begin
      set_plain();
      vlen_i = 2'(v); data_i = rnd_vec(); mat_i = rnd_vec(); const_i = 8'hff;
      mask_en_i = 1; mask_i = NB'(rnd_vec()); prev_i = rnd_vec();
      run_op("R4 vector length");
    end
  endtask

  task automatic t_merge();
    for (int n = 0; n < 3; n++) begin
      set_plain();
      data_i = rnd_vec(); mat_i = rnd_vec(); prev_i = rnd_vec();
      mask_en_i = 1; mask_i = NB'(rnd_vec()); const_i = 8'($urandom);
      run_op("R6 merge");
    end
  endtask

  task automatic t_zero();
    for (int n = 0; n < 3; n++) begin
      set_plain();
      data_i = rnd_vec(); mat_i = rnd_vec(); prev_i = rnd_vec();
      mask_en_i = 1; zero_mode_i = 1; mask_i = NB'(rnd_vec());
      const_i = 8'($urandom);
      run_op("R7 zeroing");
    end
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    repeat (2) @(posedge clk);
    #1 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_identity();
    t_single_bit();
    t_random_plain();
    t_bcast();
    t_vlen();
    t_merge();
    t_zero();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule